// File: doc/BRIEF.md
# Receive Frame Delimiter Checker

This block sits behind the symbol decoder of a serial link receiver and watches the stream of decoded symbols. Each cycle carries a valid strobe and a three-bit symbol kind. The kinds are idle, data, start-of-frame, end-of-frame, a flow-control message header, or a control character the receiver does not know. The block keeps two bits of state: whether a frame is currently open, and whether any data symbol has arrived since that frame started. From these bits it decides whether the current symbol breaks the framing rules.

A symbol that breaks the rules produces a one-cycle pulse on `frame_err` in the cycle after it is accepted. Flow-control message headers carry a byte-count field alongside the kind. The block also checks that count against the legal set. The block does not decode symbols, buffer data, or remove bad frames from the user stream. It only reports the violation.

Top module: `rx_delim_check`

## Requirements
- R1: A start-of-frame (kind 2) accepted while a frame is open is a violation; the new start then opens a fresh frame with the data-seen flag cleared.
- R2: An end-of-frame (kind 3) accepted while no frame is open is a violation.
- R3: An end-of-frame that closes a frame with no data symbol (kind 1) since its start is a violation; idle symbols (kind 0) inside a frame do not count as data.
- R4: Any kind of 5, 6 or 7 (unrecognized control character) is a violation whether or not a frame is open.
- R5: A flow-control header (kind 4) is a violation unless its `msg_len` byte count is even and between 2 and 16 inclusive.
- R6: `frame_err` is high in exactly the cycle after a violating symbol is accepted and low otherwise; back-to-back violations give back-to-back high cycles, and nothing is accepted while `sym_valid` is low.
- R7: A frame with one or more data symbols closes without error; a data symbol outside a frame is ignored; a flow-control header inside a frame does not count as data.
- R8: Synchronous reset (`rst` high at a clock edge) clears `frame_err`, closes any open frame and clears the data-seen flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A symbol is present this cycle |
| sym_kind | input | 3 | 0 idle, 1 data, 2 start, 3 end, 4 flow-control header, 5 to 7 unknown control |
| msg_len | input | LEN_W (5) | Byte count of a flow-control message, sampled with kind 4 |
| frame_err | output | 1 | One-cycle violation pulse |

## Verification
Legal frames of one and several data symbols, with idles mixed in, separate correct tracking from a checker that reports too much. Paired starts, lone ends and empty frames each cut one pairing rule on its own. A start-start-end sequence shows whether the second start really clears the data-seen flag. The full sweep of 32 length values shows the exact edges of the legal set, and a reset in the middle of a frame shows that the open state is dropped.

// File: rtl/rx_delim_check.sv
module rx_delim_check #(
  parameter int LEN_W   = 5,
  parameter int LEN_MIN = 2,
  parameter int LEN_MAX = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [2:0]       sym_kind,
  input  logic [LEN_W-1:0] msg_len,
  output logic             frame_err
);
  localparam logic [2:0] K_DATA = 3'd1;
  localparam logic [2:0] K_SOF  = 3'd2;
  localparam logic [2:0] K_EOF  = 3'd3;
  localparam logic [2:0] K_UFC  = 3'd4;

  logic in_frame, got_data;

  wire is_sof  = sym_valid && sym_kind == K_SOF;
  wire is_eof  = sym_valid && sym_kind == K_EOF;
  wire is_data = sym_valid && sym_kind == K_DATA;
  wire is_ufc  = sym_valid && sym_kind == K_UFC;
  wire is_bad  = sym_valid && sym_kind > K_UFC;
  wire len_ok  = !msg_len[0] && msg_len >= LEN_W'(LEN_MIN) && msg_len <= LEN_W'(LEN_MAX);

  wire viol = (is_sof && in_frame) || (is_eof && !(in_frame && got_data)) ||
              (is_ufc && !len_ok) || is_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_err <= 1'b0;
      in_frame  <= 1'b0;
      got_data  <= 1'b0;
    end else begin
      frame_err <= viol;
      if (is_sof) begin
        in_frame <= 1'b1;
        got_data <= 1'b0;
      end else if (is_eof) begin
        in_frame <= 1'b0;
        got_data <= 1'b0;
      end else if (is_data && in_frame) begin
        got_data <= 1'b1;
      end
    end
  end
endmodule

module rx_delim_check_sva #(
  parameter int LEN_W   = 5,
  parameter int LEN_MIN = 2,
  parameter int LEN_MAX = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic [2:0]       sym_kind,
  input logic [LEN_W-1:0] msg_len,
  input logic             in_frame,
  input logic             got_data,
  input logic             frame_err
);
  assert_sof_in_frame_R1: assert property (@(posedge clk) disable iff (rst)
    sym_valid && sym_kind == 3'd2 && in_frame |=> frame_err && in_frame && !got_data);
  assert_eof_closed_R2: assert property (@(posedge clk) disable iff (rst)
    sym_valid && sym_kind == 3'd3 && !in_frame |=> frame_err);
  assert_empty_frame_R3: assert property (@(posedge clk) disable iff (rst)
    sym_valid && sym_kind == 3'd3 && in_frame && !got_data |=> frame_err && !in_frame);
  assert_unknown_ctrl_R4: assert property (@(posedge clk) disable iff (rst)
    sym_valid && sym_kind[2] && sym_kind[1:0] != 2'd0 |=> frame_err);
  assert_bad_len_R5: assert property (@(posedge clk) disable iff (rst)
    sym_valid && sym_kind == 3'd4 &&
    (msg_len[0] || int'(msg_len) < LEN_MIN || int'(msg_len) > LEN_MAX) |=> frame_err);
  assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> !frame_err && $stable(in_frame) && $stable(got_data));
  assert_good_close_R7: assert property (@(posedge clk) disable iff (rst)
    sym_valid && sym_kind == 3'd3 && in_frame && got_data |=> !frame_err && !in_frame);
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> !frame_err && !in_frame && !got_data);
endmodule

bind rx_delim_check rx_delim_check_sva #(.LEN_W(LEN_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_sva (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_kind(sym_kind), .msg_len(msg_len),
  .in_frame(in_frame), .got_data(got_data), .frame_err(frame_err));

// File: tb/test_rx_delim_check.sv
module test_rx_delim_check;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_valid = 1'b0;
  logic [2:0] sym_kind = 3'd0;
  logic [4:0] msg_len = 5'd0;
  logic       frame_err;
  int total = 0;
  int fails = 0;

  rx_delim_check i_rx_delim_check (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_kind(sym_kind),
    .msg_len(msg_len), .frame_err(frame_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic exp, input string tag);
    total++;
    if (frame_err !== exp) begin
      fails++;
      $display("FAIL %s: frame_err=%b expected=%b", tag, frame_err, exp);
    end
  endtask

  task automatic sym(input logic [2:0] k, input logic [4:0] len, input logic exp, input string tag);
    sym_valid = 1'b1; sym_kind = k; msg_len = len;
    @(negedge clk);
    sym_valid = 1'b0;
    chk(exp, tag);
  endtask

  task automatic gap(input string tag);
    @(negedge clk);
    chk(1'b0, tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(1'b0, "R8 reset state");
    rst = 1'b0;
  endtask

  task automatic t_legal();
    sym(3'd2, 0, 0, "R7 start");
    sym(3'd1, 0, 0, "R7 one data");
    sym(3'd3, 0, 0, "R7 close single-data frame");
    sym(3'd2, 0, 0, "R7 start");
    sym(3'd0, 0, 0, "R7 idle");
    sym(3'd1, 0, 0, "R7 data");
    sym(3'd1, 0, 0, "R7 data");
    sym(3'd4, 5'd8, 0, "R7 legal ufc in frame");
    sym(3'd3, 0, 0, "R7 close multi-data frame");
    sym(3'd1, 0, 0, "R7 data outside frame ignored");
    gap("R6 no pulse on gap");
  endtask

  task automatic t_double_sof();
    sym(3'd2, 0, 0, "R1 start");
    sym(3'd1, 0, 0, "R1 data");
    sym(3'd2, 0, 1, "R1 second start");
    sym(3'd3, 0, 1, "R1 fresh frame is empty");
    gap("R6 pulse is one cycle");
  endtask

  task automatic t_lone_eof();
    sym(3'd3, 0, 1, "R2 end while closed");
    sym(3'd3, 0, 1, "R6 back-to-back end pulses");
    gap("R6 pulse ends");
  endtask

  task automatic t_empty();
    sym(3'd2, 0, 0, "R3 start");
    sym(3'd3, 0, 1, "R3 empty frame");
    sym(3'd2, 0, 0, "R3 start");
    sym(3'd0, 0, 0, "R3 idle");
    sym(3'd4, 5'd2, 0, "R3 ufc");
    sym(3'd3, 0, 1, "R3 idle and ufc not data");
  endtask

  task automatic t_unknown();
    for (int k = 5; k < 8; k++) sym(3'(k), 0, 1, "R4 unknown control closed");
    sym(3'd2, 0, 0, "R4 start");
    sym(3'd7, 0, 1, "R4 unknown control in frame");
    sym(3'd1, 0, 0, "R4 data");
    sym(3'd3, 0, 0, "R4 frame still intact");
    sym_kind = 3'd7; msg_len = 5'd1;
    @(negedge clk);
    chk(1'b0, "R6 invalid strobe low ignored");
  endtask

  task automatic t_lengths();
    for (int n = 0; n < 32; n++) begin
      logic bad;
      bad = (n % 2 == 1) || n < 2 || n > 16;
      sym(3'd4, 5'(n), bad, $sformatf("R5 ufc length %0d", n));
    end
  endtask

  task automatic t_reset_mid();
    sym(3'd2, 0, 0, "R8 start");
    sym(3'd1, 0, 0, "R8 data");
    rst = 1'b1;
    @(negedge clk);
    chk(1'b0, "R8 reset in frame");
    rst = 1'b0;
    sym(3'd3, 0, 1, "R8 frame closed by reset");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog: expired expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_legal();
    t_double_sof();
    t_lone_eof();
    t_empty();
    t_unknown();
    t_lengths();
    t_reset_mid();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule